// File: doc/BRIEF.md
# Page Buffer Load and Write-Cycle Controller

This block is the device-side load path of a byte-addressed, page-programmed non-volatile memory, in a synchronous model. Byte-write strobes each carry a 17-bit address and a data byte. The block gathers them into a 128-byte page buffer. A gap timer watches the spacing between loads. When no new byte arrives before the gap timer runs out, the block starts an internally timed write cycle. At the end of that cycle the whole page goes into a behavioural storage array in a single step.

There is no explicit commit command. Inactivity alone ends the load phase. The destination page is the page of the most recently loaded byte, and every buffer position that was not loaded is stored as FFh. While the write cycle runs, the block raises a busy flag and refuses new loads. When the cycle ends it gives a one-cycle completion pulse. The array can be read combinationally at any time. It keeps its old contents until the write completes.

Top module: `page_commit_ctrl`

## Requirements
- R1: Address bits [6:0] select the byte within the page buffer and bits [16:7] select the page. The behavioural array holds ARRAY_PAGES pages and uses the page number modulo ARRAY_PAGES, on both writes and reads.
- R2: A strobe is accepted only when chip_en is 1 and out_en is 0. A strobe with chip_en at 0 or out_en at 1 loads nothing and starts no write cycle.
- R3: Each accepted strobe restarts the gap timer. A strobe accepted on the very clock edge at which the timeout would otherwise expire keeps the block in the load phase.
- R4: busy rises on the clock edge that comes GAP_TICKS edges after the edge that accepted the last byte.
- R5: busy stays high for exactly WRITE_TICKS cycles. done is high for exactly one cycle, the first cycle in which busy is low again.
- R6: Loading the same byte position twice within one page keeps only the later data.
- R7: The whole buffer is written to the page of the last byte loaded, replacing all 128 bytes of that page in one step. Other pages are untouched.
- R8: Buffer positions not loaded since the previous commit are written as FFh. The loaded-byte record is cleared at each commit.
- R9: Strobes are ignored while busy is high. Such a strobe neither changes the buffer nor triggers a later write cycle.
- R10: After reset, busy and done are 0 and every array byte reads FFh. The array keeps its previous contents while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Byte-write strobe, one cycle per byte |
| chip_en | input | 1 | Chip enable; strobes count only when 1 |
| out_en | input | 1 | Output enable; strobes are blocked when 1 |
| wr_addr | input | 17 | Byte address: page in [16:7], offset in [6:0] |
| wr_data | input | 8 | Data byte for the strobe |
| rd_addr | input | 17 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| busy | output | 1 | High while the internal write cycle runs |
| done | output | 1 | One-cycle pulse when a write cycle completes |

## Verification
Two events can land on the same clock edge: a new byte strobe and the expiry of the gap timer. The bench loads one byte, waits until the edge on which the timeout would fire, and places the next strobe on exactly that edge. It then checks that busy is still low one cycle later and that it rises GAP_TICKS edges after the second byte. The bench also places a strobe inside the busy window. It confirms that the page read back afterwards does not contain that byte and that no second write cycle follows.

// File: rtl/pgc_pkg.sv
`timescale 1ns/1ps
package pgc_pkg;
  localparam int ADDR_W     = 17;
  localparam int OFFS_W     = 7;
  localparam int DATA_W     = 8;
  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  // byte position inside a page
  function automatic logic [OFFS_W-1:0] byte_of(input logic [ADDR_W-1:0] a);
    return a[OFFS_W-1:0];
  endfunction

  // page number carried by an address
  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFFS_W];
  endfunction

  // value a buffer position contributes to the committed page
  function automatic logic [DATA_W-1:0] merge_byte(input logic loaded,
                                                   input logic [DATA_W-1:0] d);
    return loaded ? d : ERASED;
  endfunction
endpackage

// File: rtl/pgc_gate.sv
`timescale 1ns/1ps
module pgc_gate (
  input  logic wr_stb,
  input  logic chip_en,
  input  logic out_en,
  input  logic busy,
  output logic accept
);
  logic enabled;
  assign enabled = chip_en && !out_en;
  assign accept  = wr_stb && enabled && !busy;
endmodule

// File: rtl/pgc_buffer.sv
`timescale 1ns/1ps
module pgc_buffer
  import pgc_pkg::*;
#(
  parameter int BYTES = PAGE_BYTES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic                      clear,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [PAGE_W-1:0]         page_q,
  output logic [BYTES*DATA_W-1:0]   image
);
  logic [DATA_W-1:0] data_q [BYTES];
  logic [BYTES-1:0]  mask_q;
  logic [OFFS_W-1:0] slot;

  assign slot = byte_of(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
    end else begin
      if (clear)
        mask_q <= '0;
      if (accept) begin
        mask_q[slot] <= 1'b1;
        page_q       <= page_of(addr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      data_q[slot] <= wdata;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_img
    assign image[i*DATA_W +: DATA_W] = merge_byte(mask_q[i], data_q[i]);
  end

  // R8: a commit leaves no byte marked as loaded
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask_q == '0));

  // R6: the latest write to a slot is what the image carries
  assert_slot_latest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (image[$past(slot)*DATA_W +: DATA_W] == $past(wdata)));
endmodule

// File: rtl/pgc_timer.sv
`timescale 1ns/1ps
module pgc_timer #(
  parameter int GAP_TICKS   = 20000,
  parameter int WRITE_TICKS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic finish,
  output logic done
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam int WW = $clog2(WRITE_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WRITE} phase_t;
  phase_t        phase;
  logic [GW-1:0] gap_cnt;
  logic [WW-1:0] wr_cnt;
  logic          loading;
  logic          gap_expire;

  assign loading    = (phase == ST_LOAD);
  assign busy       = (phase == ST_WRITE);
  assign gap_expire = loading && !accept && (gap_cnt == GW'(GAP_TICKS - 1));
  assign finish     = busy && (wr_cnt == WW'(WRITE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      gap_cnt <= '0;
      wr_cnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      unique case (phase)
        ST_IDLE: if (accept) begin
          phase   <= ST_LOAD;
          gap_cnt <= '0;
        end
        ST_LOAD: begin
          if (accept) begin
            gap_cnt <= '0;
          end else if (gap_expire) begin
            phase  <= ST_WRITE;
            wr_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_WRITE: begin
          if (finish) phase  <= ST_IDLE;
          else        wr_cnt <= wr_cnt + 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R3: the gap counter never passes its limit
  assert_gap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> (gap_cnt < GW'(GAP_TICKS)));

  // R3: an accepted byte restarts the gap timer and stays in load phase
  assert_accept_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (loading && gap_cnt == '0));

  // R4: a write cycle only ever begins from the load phase
  assert_busy_from_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));

  // R5: completion pulse lasts one cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: completion pulse marks the first idle cycle after busy
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/pgc_array.sv
`timescale 1ns/1ps
module pgc_array
  import pgc_pkg::*;
#(
  parameter int PAGES = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [PAGE_W-1:0]              page_sel,
  input  logic [PAGE_BYTES*DATA_W-1:0]   image,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int ROW_W = PAGE_BYTES * DATA_W;

  // fold an address page onto the stored rows
  function automatic logic [PW-1:0] row_of(input logic [PAGE_W-1:0] pg);
    return PW'(pg % PAGES);
  endfunction

  logic [ROW_W-1:0]  rows [PAGES];
  logic [PW-1:0]     wr_row;
  logic [PW-1:0]     rd_row;
  logic [OFFS_W-1:0] rd_byte;

  assign wr_row  = row_of(page_sel);
  assign rd_row  = row_of(page_of(rd_addr));
  assign rd_byte = byte_of(rd_addr);
  assign rd_data = rows[rd_row][rd_byte*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        rows[p] <= '1;
    end else if (commit) begin
      rows[wr_row] <= image;
    end
  end

  // R7: the full buffer image lands in the selected row
  assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (rows[$past(wr_row)] == $past(image)));
endmodule

// File: rtl/page_commit_ctrl.sv
`timescale 1ns/1ps
module page_commit_ctrl
  import pgc_pkg::*;
#(
  parameter int GAP_TICKS   = 20000,
  parameter int WRITE_TICKS = 1000000,
  parameter int ARRAY_PAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  logic                         accept;
  logic                         finish;
  logic [PAGE_W-1:0]            page_q;
  logic [PAGE_BYTES*DATA_W-1:0] image;

  pgc_gate u_gate (
    .wr_stb (wr_stb),
    .chip_en(chip_en),
    .out_en (out_en),
    .busy   (busy),
    .accept (accept)
  );

  pgc_buffer #(.BYTES(PAGE_BYTES)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .clear (finish),
    .addr  (wr_addr),
    .wdata (wr_data),
    .page_q(page_q),
    .image (image)
  );

  pgc_timer #(.GAP_TICKS(GAP_TICKS), .WRITE_TICKS(WRITE_TICKS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .busy  (busy),
    .finish(finish),
    .done  (done)
  );

  pgc_array #(.PAGES(ARRAY_PAGES)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (finish),
    .page_sel(page_q),
    .image   (image),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R2: a blocked strobe is never taken
  assert_blocked_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (!chip_en || out_en)) |-> !accept);

  // R9: nothing is taken during the write cycle
  assert_busy_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R10: array contents hold during the write cycle except on its last edge
  assert_array_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && $stable(rd_addr)) |=> $stable(rd_data));
endmodule

// File: tb/tb_page_commit_ctrl.sv
`timescale 1ns/1ps
module tb_page_commit_ctrl;
  localparam int GAP   = 20;
  localparam int WRT   = 30;
  localparam int PAGES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, chip_en = 1'b1, out_en = 1'b0;
  logic [16:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        busy, done;

  page_commit_ctrl #(.GAP_TICKS(GAP), .WRITE_TICKS(WRT), .ARRAY_PAGES(PAGES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .chip_en(chip_en), .out_en(out_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  typedef struct { int page; logic [1023:0] img; } exp_t;
  exp_t       sb_q[$];
  logic [7:0] m_data [128];
  bit         m_mask [128];
  int         m_page;
  logic [7:0] m_arr [PAGES][128];
  int         checks = 0, errors = 0;
  bit         finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_at(input int a, output logic [7:0] v);
    rd_addr = 17'(a);
    #0.1;
    v = rd_data;
  endtask

  task automatic raw_stb(input int a, input int d, input bit ce, input bit oe);
    wr_addr = 17'(a); wr_data = 8'(d); chip_en = ce; out_en = oe; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; chip_en = 1'b1; out_en = 1'b0;
  endtask

  task automatic load(input int a, input int d);
    raw_stb(a, d, 1'b1, 1'b0);
    m_data[a % 128] = 8'(d);
    m_mask[a % 128] = 1'b1;
    m_page = (a / 128) % PAGES;
  endtask

  task automatic push_commit();
    exp_t e;
    e.page = m_page;
    for (int i = 0; i < 128; i++) begin
      e.img[i*8 +: 8] = m_mask[i] ? m_data[i] : 8'hFF;
      m_arr[m_page][i] = e.img[i*8 +: 8];
      m_mask[i] = 1'b0;
    end
    sb_q.push_back(e);
  endtask

  // called right after the last load returns
  task automatic wait_commit(input bit poke);
    logic [7:0] v;
    repeat (GAP - 1) @(negedge clk);
    check(busy == 1'b0, "R4", "busy one cycle before expiry", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R4", "busy at expiry", busy, 1);
    read_at(m_page * 128, v);
    check(v == m_arr[m_page][0], "R10", "old data during busy", v, m_arr[m_page][0]);
    push_commit();
    if (poke) begin
      raw_stb(m_page * 128 + 1, 8'h5A, 1'b1, 1'b0);  // R9: strobe while busy
      repeat (WRT - 2) @(negedge clk);
    end else begin
      repeat (WRT - 1) @(negedge clk);
    end
    check(busy == 1'b1, "R5", "busy in last write cycle", busy, 1);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b1, "R5", "done after write", {busy, done}, 2'b01);
    @(negedge clk);
    check(done == 1'b0, "R5", "done width", done, 0);
    repeat (20) @(negedge clk);
    if (poke) begin
      repeat (GAP + 5) @(negedge clk);
      check(busy == 1'b0, "R9", "no commit from busy strobe", busy, 0);
    end
  endtask

  // scoreboard monitor: on each completion, compare the whole committed page
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected commit", 1, 0);
        end else begin
          exp_t e;
          int bad = 0, first = -1;
          logic [7:0] got = '0, want = '0;
          e = sb_q.pop_front();
          for (int i = 0; i < 128; i++) begin
            rd_addr = 17'(e.page * 128 + i);
            #0.1;
            if (rd_data !== e.img[i*8 +: 8]) begin
              if (first < 0) begin first = i; got = rd_data; want = e.img[i*8 +: 8]; end
              bad++;
            end
          end
          check(bad == 0, "R7", $sformatf("page %0d byte %0d", e.page, first), got, want);
        end
      end
    end
  end

  initial begin
    #(8.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int p = 0; p < PAGES; p++)
      for (int i = 0; i < 128; i++) m_arr[p][i] = 8'hFF;
    for (int i = 0; i < 128; i++) begin m_mask[i] = 1'b0; m_data[i] = '0; end
    m_page = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10", "reset flags", {busy, done}, 0);
    read_at(0, v);            check(v == 8'hFF, "R10", "reset byte 0", v, 8'hFF);
    read_at(17'h1ABCD, v);    check(v == 8'hFF, "R10", "reset byte high", v, 8'hFF);

    // R8, R9: partial page, strobe during busy
    load(5*128 + 0, 8'h11);
    load(5*128 + 2, 8'h22);
    load(5*128 + 127, 8'h33);
    wait_commit(1'b1);

    // R6, R7: overwrite and page from last byte
    load(3*128 + 4, 8'h44);
    load(3*128 + 4, 8'h45);
    load(3*128 + 9, 8'h99);
    load(7*128 + 10, 8'hA0);
    wait_commit(1'b0);
    read_at(7*128 + 4, v);   check(v == 8'h45, "R6", "later write kept", v, 8'h45);
    read_at(3*128 + 4, v);   check(v == 8'hFF, "R7", "other page untouched", v, 8'hFF);

    // R8: loaded record cleared after commit
    load(2*128 + 1, 8'h12);
    wait_commit(1'b0);
    read_at(2*128 + 4, v);   check(v == 8'hFF, "R8", "stale slot erased", v, 8'hFF);

    // R3: strobe on the expiry edge keeps loading
    load(6*128 + 0, 8'h60);
    repeat (GAP - 1) @(negedge clk);
    check(busy == 1'b0, "R3", "before expiry edge", busy, 0);
    load(6*128 + 1, 8'h61);
    check(busy == 1'b0, "R3", "expiry suppressed by strobe", busy, 0);
    wait_commit(1'b0);

    // R2: blocked strobes
    raw_stb(8*128 + 3, 8'h77, 1'b0, 1'b0);
    raw_stb(8*128 + 3, 8'h78, 1'b1, 1'b1);
    repeat (GAP + 5) @(negedge clk);
    check(busy == 1'b0, "R2", "no write cycle from blocked strobes", busy, 0);
    read_at(8*128 + 3, v);   check(v == 8'hFF, "R2", "blocked data absent", v, 8'hFF);

    // R1: full page, page number above the array folds modulo
    for (int i = 0; i < 128; i++) load(25*128 + i, (i*7 + 3) & 255);
    wait_commit(1'b0);
    read_at(9*128 + 5, v);   check(v == 8'h26, "R1", "folded page byte 5", v, 8'h26);
    read_at(25*128 + 127, v); check(v == 8'(127*7 + 3), "R1", "alias read byte 127", v, 8'(127*7 + 3));

    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R5", "all commits completed", sb_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule